// File: doc/BRIEF.md
# Lane Margin Control Skip Set Generator

This block builds one control skip ordered set for a single lane and sends it out as a stream of 8-bit symbols. A one-cycle start request loads a group count N and a snapshot of the margin control fields. The block then sends 4*N filler symbols, one end-of-control marker and three trailer symbols. The trailer carries three parity flags, a 5-bit margin CRC, a margin parity bit and the margin command itself: the usage model, margin type, receiver number and payload.

A mode pin selects which command is sent. In root-port mode the trailer copies the control fields as they stood when the start request was taken. In endpoint mode the trailer always holds a fixed no-command encoding. In both modes the CRC and parity are worked out over the fields that are actually sent.

The output is a valid/ready stream. A symbol is transferred on any clock edge where both `sym_valid_o` and `sym_ready_i` are high. While `sym_valid_o` is high and `sym_ready_i` is low, the symbol stays unchanged and the sequence waits, with no limit on how long. `sym_valid_o` never drops in the middle of a set. Scrambling, block framing, scheduling against data blocks and retimer parity generation are outside the block: the parity flags come in on pins.

Top module: `ctl_skip_tx`

## Requirements
- R1: After reset, `sym_valid_o` and `busy_o` are low.
- R2: A start request taken while idle begins a set in the next cycle. The first 4*N symbols are AAh, the first of them serving as the set identifier. N is `groups_i`, and a value of 0 is treated as 1.
- R3: The filler symbols are followed by 78h and then by exactly three trailer symbols. After the last trailer symbol is transferred, `sym_valid_o` goes low.
- R4: Trailer symbol 1 carries data parity in bit 7, first-retimer parity in bit 6, second-retimer parity in bit 5 and margin CRC[4:0] in bits 4:0.
- R5: Trailer symbol 2 carries margin parity in bit 7, the usage model in bit 6 (0 means receiver lane margining), the margin type in bits 5:3 and the receiver number in bits 2:0.
- R6: Trailer symbol 3 is the 8-bit margin payload.
- R7: In root-port mode (`ep_mode_i`=0), the usage model, type, receiver number and payload that are sent equal the input values at the start request.
- R8: In endpoint mode (`ep_mode_i`=1), the trailer sends usage model 0, type 3'b111, receiver 3'b000 and payload 9Ch.
- R9: The margin CRC uses polynomial x^5+x^2+1 with a zero seed. It runs MSB first over 16 bits: trailer-2 bits [6:0], then the payload, then one 0 bit.
- R10: The margin parity bit makes the XOR of itself, the five CRC bits and trailer-2 bits [6:0] equal zero (even parity).
- R11: While `sym_valid_o` is high and `sym_ready_i` is low, `sym_data_o` holds its value and no symbol is skipped or repeated.
- R12: The fields, the mode and the parity flags are sampled only at the start request. Input changes and further start requests while busy have no effect on the set being sent.
- R13: `busy_o` is high from the cycle after the start request until the last trailer symbol is transferred. It is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| groups_i | input | CNT_W | Number of four-symbol filler groups N (0 treated as 1) |
| ep_mode_i | input | 1 | 1 = endpoint mode, 0 = root-port mode |
| usage_i | input | 1 | Usage model field |
| mtype_i | input | 3 | Margin type field |
| rxnum_i | input | 3 | Receiver number field |
| payload_i | input | 8 | Margin payload field |
| dpar_i | input | 1 | Data parity flag |
| rt1_par_i | input | 1 | First-retimer parity flag |
| rt2_par_i | input | 1 | Second-retimer parity flag |
| sym_ready_i | input | 1 | Downstream ready to take a symbol |
| sym_valid_o | output | 1 | Symbol on `sym_data_o` is valid |
| sym_data_o | output | 8 | Symbol value |
| busy_o | output | 1 | A set is being sent |

## Verification
The bench sweeps every margin type and receiver number in both modes and for each usage value. It varies N from 0 to 4 and also runs the largest N. A design that fed the CRC in the wrong bit order, or left out the pad bit, would send wrong low bits in trailer 1. Odd parity in place of even would flip bit 7 of trailer 2. Half the sets stall the stream with a low ready, so a design that moved on while stalled would skip or duplicate a symbol. After each start, the bench scrambles the fields and the mode and sends a second start during the set. A design that read the fields live would send a mixed trailer, and one that re-armed on that start would restart the set. Treating N=0 as zero groups would make the first symbol 78h in place of the identifier.

// File: rtl/ctl_skp_pkg.sv
package ctl_skp_pkg;
  localparam int SYM_W   = 8;
  localparam int TYPE_W  = 3;
  localparam int RX_W    = 3;
  localparam int CRC_W   = 5;
  localparam int CRC_IN_W = 16;

  localparam logic [SYM_W-1:0]  SKP_SYM       = 8'hAA;
  localparam logic [SYM_W-1:0]  END_SYM       = 8'h78;
  localparam logic [TYPE_W-1:0] NOCMD_TYPE    = 3'b111;
  localparam logic [RX_W-1:0]   NOCMD_RX      = 3'b000;
  localparam logic [SYM_W-1:0]  NOCMD_PAYLOAD = 8'h9C;
  localparam logic [CRC_W-1:0]  CRC_POLY      = 5'b00101;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SKP  = 3'd1,
    PH_END  = 3'd2,
    PH_TR1  = 3'd3,
    PH_TR2  = 3'd4,
    PH_TR3  = 3'd5
  } phase_e;

  typedef struct packed {
    logic              usage;
    logic [TYPE_W-1:0] mtype;
    logic [RX_W-1:0]   rxnum;
    logic [SYM_W-1:0]  payload;
    logic              dpar;
    logic              r1par;
    logic              r2par;
  } ctl_fields_t;
endpackage

// File: rtl/ctl_skp_crc.sv
module ctl_skp_crc #(
  parameter int DATA_W = 16,
  parameter int CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY = 5'b00101
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = '0;

  // One LFSR step per input bit, MSB of data_i first.
  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic fb;
    assign fb = stage[i][CRC_W-1] ^ data_i[DATA_W-1-i];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/ctl_skp_fields.sv
module ctl_skp_fields
  import ctl_skp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              ep_mode_i,
  input  ctl_fields_t       raw_i,
  output logic              ep_q_o,
  output logic [SYM_W-1:0]  tr1_o,
  output logic [SYM_W-1:0]  tr2_o,
  output logic [SYM_W-1:0]  tr3_o
);
  ctl_fields_t sel_d;
  ctl_fields_t cur_q;
  logic        ep_q;
  logic [6:0]  cmd_bits;
  logic [CRC_W-1:0] crc;
  logic        mpar;

  // Endpoint mode swaps in the fixed no-command values; parity flags pass through.
  always_comb begin
    sel_d = raw_i;
    if (ep_mode_i) begin
      sel_d.usage   = 1'b0;
      sel_d.mtype   = NOCMD_TYPE;
      sel_d.rxnum   = NOCMD_RX;
      sel_d.payload = NOCMD_PAYLOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      ep_q  <= 1'b0;
    end else if (capture_i) begin
      cur_q <= sel_d;
      ep_q  <= ep_mode_i;
    end
  end

  assign cmd_bits = {cur_q.usage, cur_q.mtype, cur_q.rxnum};

  ctl_skp_crc #(
    .DATA_W (CRC_IN_W),
    .CRC_W  (CRC_W),
    .POLY   (CRC_POLY)
  ) u_crc (
    .data_i ({cmd_bits, cur_q.payload, 1'b0}),
    .crc_o  (crc)
  );

  assign mpar   = ^{crc, cmd_bits};
  assign tr1_o  = {cur_q.dpar, cur_q.r1par, cur_q.r2par, crc};
  assign tr2_o  = {mpar, cmd_bits};
  assign tr3_o  = cur_q.payload;
  assign ep_q_o = ep_q;

  AST_EP_NOCMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ep_q |-> (cur_q.mtype == NOCMD_TYPE && cur_q.rxnum == NOCMD_RX
              && cur_q.payload == NOCMD_PAYLOAD && !cur_q.usage)); // R8
  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(cur_q) && $stable(ep_q)); // R12
endmodule

// File: rtl/ctl_skp_seq.sv
module ctl_skp_seq
  import ctl_skp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] groups_i,
  input  logic             ready_i,
  output logic             capture_o,
  output phase_e           phase_o,
  output logic             valid_o,
  output logic             busy_o
);
  localparam int LEFT_W = CNT_W + 2;

  phase_e            phase_q;
  logic [LEFT_W-1:0] left_q;
  logic [CNT_W-1:0]  groups_eff;
  logic              fire;

  assign groups_eff = (groups_i == '0) ? CNT_W'(1) : groups_i;
  assign valid_o    = (phase_q != PH_IDLE);
  assign busy_o     = valid_o;
  assign fire       = valid_o && ready_i;
  assign capture_o  = start_i && (phase_q == PH_IDLE);
  assign phase_o    = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (capture_o) begin
          phase_q <= PH_SKP;
          left_q  <= {groups_eff, 2'b00} - LEFT_W'(1);
        end
        PH_SKP: if (fire) begin
          if (left_q == '0) phase_q <= PH_END;
          else              left_q  <= left_q - LEFT_W'(1);
        end
        PH_END:  if (fire) phase_q <= PH_TR1;
        PH_TR1:  if (fire) phase_q <= PH_TR2;
        PH_TR2:  if (fire) phase_q <= PH_TR3;
        PH_TR3:  if (fire) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> (phase_q == PH_SKP)); // R2
  AST_END_AFTER_SKP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKP && fire && left_q == '0) |=> (phase_q == PH_END)); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(phase_q) && $stable(left_q)); // R11
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(phase_q == PH_TR3 && fire)) |=> busy_o); // R13
endmodule

// File: rtl/ctl_skip_tx.sv
module ctl_skip_tx
  import ctl_skp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] groups_i,
  input  logic             ep_mode_i,
  input  logic             usage_i,
  input  logic [2:0]       mtype_i,
  input  logic [2:0]       rxnum_i,
  input  logic [7:0]       payload_i,
  input  logic             dpar_i,
  input  logic             rt1_par_i,
  input  logic             rt2_par_i,
  input  logic             sym_ready_i,
  output logic             sym_valid_o,
  output logic [7:0]       sym_data_o,
  output logic             busy_o
);
  ctl_fields_t      raw;
  logic             capture;
  phase_e           phase;
  logic             ep_q;
  logic [SYM_W-1:0] tr1, tr2, tr3;

  assign raw = '{usage: usage_i, mtype: mtype_i, rxnum: rxnum_i, payload: payload_i,
                 dpar: dpar_i, r1par: rt1_par_i, r2par: rt2_par_i};

  ctl_skp_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .groups_i  (groups_i),
    .ready_i   (sym_ready_i),
    .capture_o (capture),
    .phase_o   (phase),
    .valid_o   (sym_valid_o),
    .busy_o    (busy_o)
  );

  ctl_skp_fields u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .ep_mode_i (ep_mode_i),
    .raw_i     (raw),
    .ep_q_o    (ep_q),
    .tr1_o     (tr1),
    .tr2_o     (tr2),
    .tr3_o     (tr3)
  );

  always_comb begin
    unique case (phase)
      PH_SKP:  sym_data_o = SKP_SYM;
      PH_END:  sym_data_o = END_SYM;
      PH_TR1:  sym_data_o = tr1;
      PH_TR2:  sym_data_o = tr2;
      PH_TR3:  sym_data_o = tr3;
      default: sym_data_o = '0;
    endcase
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && !sym_ready_i) |=> $stable(sym_data_o)); // R11
  AST_FIRST_IS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sym_valid_o) |-> (sym_data_o == SKP_SYM)); // R2
  AST_EP_TR2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && phase == PH_TR2 && ep_q) |-> (sym_data_o[6:0] == 7'b0111000)); // R8
  AST_TR2_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && phase == PH_TR1) |=> (^{$past(sym_data_o[4:0]), tr2} == 1'b0)); // R10
endmodule

// File: tb/ctl_skip_tx_bench.sv
module ctl_skip_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] groups_i = '0;
  logic       ep_mode_i = 1'b0, usage_i = 1'b0;
  logic [2:0] mtype_i = '0, rxnum_i = '0;
  logic [7:0] payload_i = '0;
  logic       dpar_i = 1'b0, rt1_par_i = 1'b0, rt2_par_i = 1'b0;
  logic       sym_ready_i = 1'b0;
  logic       sym_valid_o, busy_o;
  logic [7:0] sym_data_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ctl_skip_tx u_ctl_skip_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .groups_i(groups_i),
    .ep_mode_i(ep_mode_i), .usage_i(usage_i), .mtype_i(mtype_i), .rxnum_i(rxnum_i),
    .payload_i(payload_i), .dpar_i(dpar_i), .rt1_par_i(rt1_par_i), .rt2_par_i(rt2_par_i),
    .sym_ready_i(sym_ready_i), .sym_valid_o(sym_valid_o), .sym_data_o(sym_data_o),
    .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected CRC from the R9 definition.
  function automatic logic [4:0] ref_crc(input logic [15:0] bits);
    logic [4:0] c = '0;
    for (int i = 15; i >= 0; i--) begin
      logic fb = c[4] ^ bits[i];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b00101;
    end
    return c;
  endfunction

  task automatic run_set(input int n, input bit ep, input bit us, input logic [2:0] mt,
                         input logic [2:0] rx, input logic [7:0] pl, input bit dp,
                         input bit p1, input bit p2, input bit stall);
    int nn = (n == 0) ? 1 : n;
    int total = 4 * nn + 4;
    int k = 0;
    int guard = 0;
    bit hold = 1'b0;
    bit rdy;
    logic [7:0] held = '0;
    logic [7:0] exp;
    logic [6:0] cmd;
    logic [7:0] spl;
    logic [4:0] crc;
    logic [7:0] t1, t2;
    string tag;
    cmd = ep ? {1'b0, 3'b111, 3'b000} : {us, mt, rx};
    spl = ep ? 8'h9C : pl;
    crc = ref_crc({cmd, spl, 1'b0});
    t1  = {dp, p1, p2, crc};
    t2  = {^{crc, cmd}, cmd};

    @(negedge clk);
    groups_i = n[3:0]; ep_mode_i = ep; usage_i = us; mtype_i = mt; rxnum_i = rx;
    payload_i = pl; dpar_i = dp; rt1_par_i = p1; rt2_par_i = p2;
    start_i = 1'b1; sym_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // Scramble everything after the start (R12).
    groups_i = groups_i + 4'd3; ep_mode_i = ~ep; usage_i = ~us; mtype_i = ~mt;
    rxnum_i = rx + 3'd5; payload_i = ~pl; dpar_i = ~dp; rt1_par_i = ~p1; rt2_par_i = ~p2;
    chk(busy_o === 1'b1, "R13 busy after start", {7'b0, busy_o}, 8'h01);

    while (k < total && guard < 2000) begin
      if (sym_valid_o !== 1'b1) begin
        chk(1'b0, "R3 valid dropped early", {7'b0, sym_valid_o}, 8'h01);
        break;
      end
      if (hold) chk(sym_data_o === held, "R11 held symbol", sym_data_o, held);
      if (k < 4 * nn)            begin exp = 8'hAA; tag = "R2 filler"; end
      else if (k == 4 * nn)      begin exp = 8'h78; tag = "R3 end marker"; end
      else if (k == 4 * nn + 1)  begin exp = t1;    tag = "R4 R9 trailer1"; end
      else if (k == 4 * nn + 2)  begin exp = t2;    tag = ep ? "R8 R10 trailer2" : "R5 R7 R10 trailer2"; end
      else                       begin exp = spl;   tag = ep ? "R8 trailer3" : "R6 R7 R12 trailer3"; end
      chk(sym_data_o === exp, tag, sym_data_o, exp);
      chk(busy_o === 1'b1, "R13 busy during set", {7'b0, busy_o}, 8'h01);
      start_i = (k == 2);  // R12: start while busy
      rdy = !stall || (((k + guard) % 3) != 0);
      sym_ready_i = rdy;
      held = sym_data_o;
      @(negedge clk);
      if (rdy) begin k++; hold = 1'b0; end
      else hold = 1'b1;
      guard++;
    end
    start_i = 1'b0;
    sym_ready_i = 1'b0;
    chk(sym_valid_o === 1'b0, "R3 R12 valid low after set", {7'b0, sym_valid_o}, 8'h00);
    chk(busy_o === 1'b0, "R13 busy low after set", {7'b0, busy_o}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sym_valid_o === 1'b0, "R1 valid in reset", {7'b0, sym_valid_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sym_valid_o === 1'b0, "R1 valid after reset", {7'b0, sym_valid_o}, 8'h00);
    chk(busy_o === 1'b0, "R1 busy after reset", {7'b0, busy_o}, 8'h00);

    for (int mt = 0; mt < 8; mt++) begin
      for (int rx = 0; rx < 8; rx++) begin
        for (int m = 0; m < 4; m++) begin
          int idx = mt * 32 + rx * 4 + m;
          run_set((mt + rx + m) % 5, m[0], m[1], mt[2:0], rx[2:0],
                  8'((mt * 37 + rx * 11 + m * 71) & 255),
                  idx[0], idx[1], idx[2], idx[3]);
        end
      end
    end
    run_set(15, 1'b0, 1'b1, 3'd5, 3'd2, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b1);
    run_set(15, 1'b1, 1'b1, 3'd1, 3'd6, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    run_set(0,  1'b0, 1'b0, 3'd0, 3'd0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule